// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives a two-channel serial audio stream in which the bit clock, the word clock and the data line are all driven from outside. It oversamples the three lines with its own system clock, finds the bit-clock rising edges, and takes data and word-clock levels at those edges. No master clock is needed. The framing is picked by a small configuration register. It can be standard I2S, MSB-first left-justified, or LSB-last right-justified. The same register sets the sample length to 16, 20 or 24 bits.

Each completed left/right pair is presented as two 24-bit words, left-aligned and zero-padded, together with a one-cycle strobe. The block also counts bit-clock rising edges from one word-clock rising edge to the next. Only 32, 48 and 64 edges per frame are accepted, and the block reports which one is present. Any other count raises an error flag. The flag stays high until two supported frames in a row have been seen, and no pair is presented while it is high.

Top module: `sa_receiver`

## Requirements
- R1: While reset is held and after it is released, left_out and right_out are zero, sample_valid is low, ratio_code is 0 and ratio_error is high; the configuration is I2S with 24-bit samples.
- R2: A cycle with cfg_wr high loads cfg_fmt (0 = I2S, 1 = left-justified, 2 = right-justified, 3 = treated as I2S) and cfg_len (0 = 16, 1 = 20, 2 or 3 = 24 bits). No pair may be built from bits received before the write.
- R3: In I2S mode the left channel occupies the word-clock-low half. Its MSB is taken one bit clock after the word-clock transition, and the final bit of a channel is taken on the first bit clock of the following half.
- R4: In left-justified mode the left channel occupies the word-clock-high half. The MSB is taken on the first bit clock of the half.
- R5: In right-justified mode the left channel occupies the word-clock-high half. The LSB is the last bit clock before the word-clock transition, and bits ahead of the sample length are ignored.
- R6: Outputs are left-aligned in 24 bits, and bits below the configured sample length are zero. A half-frame shorter than the sample length yields only the bits it carried, and the remaining positions are zero.
- R7: ratio_code reports the last measured count of bit-clock rising edges between word-clock rising edges: 1 for 32, 2 for 48, 3 for 64, and 0 for any other count.
- R8: An unsupported count sets ratio_error on that word-clock rising edge. The flag is cleared only on the second consecutive supported count.
- R9: sample_valid pulses for one cycle when the right channel of a frame completes after its left channel. The pulse happens only if ratio_error, including any update on that same bit clock, is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | External bit clock |
| lrck | input | 1 | External word clock (one period per stereo sample) |
| sdin | input | 1 | Serial data line |
| cfg_wr | input | 1 | Load strobe for the configuration register |
| cfg_fmt | input | 2 | Framing code |
| cfg_len | input | 2 | Sample length code |
| left_out | output | 24 | Left sample, left-aligned |
| right_out | output | 24 | Right sample, left-aligned |
| sample_valid | output | 1 | One-cycle strobe for a new pair |
| ratio_code | output | 2 | Measured bit clocks per frame |
| ratio_error | output | 1 | Unsupported-ratio flag |

## Verification
In both justified modes the right channel ends on the same bit clock as a word-clock rising edge. On that edge the frame length is judged and a pair may be presented, both in one cycle. The bench provokes this by first clearing the error with several 64-bit left-justified frames. It then sends one 56-bit frame and then a 64-bit frame whose opening rising edge closes the bad frame. It expects exactly one strobe across the two frames, the one for the last good frame, together with the error flag high and the earlier pair still on the outputs.

// File: rtl/sa_rx_pkg.sv
package sa_rx_pkg;

  localparam logic [1:0] FMT_I2S = 2'd0;
  localparam logic [1:0] FMT_LJ  = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;

  localparam logic [1:0] LEN_16 = 2'd0;
  localparam logic [1:0] LEN_20 = 2'd1;
  localparam logic [1:0] LEN_24 = 2'd2;

  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_32   = 2'd1,
    RATIO_48   = 2'd2,
    RATIO_64   = 2'd3
  } ratio_e;

  typedef struct packed {
    logic [1:0] fmt;
    logic [1:0] len;
  } cfg_t;

  function automatic int unsigned len_bits(logic [1:0] code);
    case (code)
      LEN_16:  return 16;
      LEN_20:  return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/sa_rx_sync.sv
module sa_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sa_rx_ratio.sv
module sa_rx_ratio
  import sa_rx_pkg::*;
#(
  parameter int RATIO_LO  = 32,
  parameter int RATIO_MID = 48,
  parameter int RATIO_HI  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step,
  input  logic       rise,
  output logic [1:0] ratio_code,
  output logic       err,
  output logic       err_next
);

  localparam int CW = $clog2(RATIO_HI) + 2;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt;
  logic [CW:0]   frame_len;
  logic          seen;
  logic [1:0]    good_cnt, good_next;
  logic          supported;
  ratio_e        code_now, code_q;

  assign frame_len = {1'b0, cnt} + (CW+1)'(1);

  always_comb begin
    code_now = RATIO_NONE;
    if (frame_len == (CW+1)'(RATIO_LO))  code_now = RATIO_32;
    if (frame_len == (CW+1)'(RATIO_MID)) code_now = RATIO_48;
    if (frame_len == (CW+1)'(RATIO_HI))  code_now = RATIO_64;
    supported = (code_now != RATIO_NONE);
    good_next = supported ? ((good_cnt == 2'd2) ? 2'd2 : good_cnt + 2'd1) : 2'd0;
    err_next  = err;
    if (rise && seen) begin
      if (!supported)             err_next = 1'b1;
      else if (good_next == 2'd2) err_next = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      seen     <= 1'b0;
      good_cnt <= 2'd0;
      err      <= 1'b1;
      code_q   <= RATIO_NONE;
    end else if (step) begin
      if (rise) begin
        cnt  <= '0;
        seen <= 1'b1;
        if (seen) begin
          good_cnt <= good_next;
          err      <= err_next;
          code_q   <= code_now;
        end
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign ratio_code = code_q;

  // R8: the flag moves only on a word-clock rising edge
  p_err_at_rise_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(err) |-> $past(rise && step));

  // R7: a cleared flag implies a supported measured ratio
  p_code_supported_r7: assert property (@(posedge clk) disable iff (rst)
    !err |-> (ratio_code != RATIO_NONE));

endmodule

// File: rtl/sa_rx_capture.sv
module sa_rx_capture
  import sa_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_MAX = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                stb,
  input  logic                din,
  input  logic                ws,
  input  logic                left_level,
  input  logic                right_just,
  input  logic [1:0]          len_code,
  input  logic                pair_ok,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                valid
);

  localparam int PW = $clog2(SLOT_MAX) + 1;
  localparam logic [SAMPLE_W-1:0] ONES = '1;

  logic [SLOT_MAX-1:0] shreg, aligned;
  logic [PW-1:0]       pos, shamt;
  logic [7:0]          len_n;
  logic [SAMPLE_W-1:0] keep_top, keep_low, msb_val, rj_val, samp, left_hold;
  logic                ws_q, armed, started, have_left;

  always_comb begin
    len_n    = 8'(len_bits(len_code));
    shamt    = PW'(SLOT_MAX) - pos;
    aligned  = shreg << shamt;
    keep_top = ~(ONES >> len_n);
    keep_low = ~(ONES << len_n);
    msb_val  = aligned[SLOT_MAX-1 -: SAMPLE_W] & keep_top;
    rj_val   = (shreg[SAMPLE_W-1:0] & keep_low) << (8'(SAMPLE_W) - len_n);
    samp     = right_just ? rj_val : msb_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      pos       <= '0;
      ws_q      <= 1'b0;
      armed     <= 1'b0;
      started   <= 1'b0;
      have_left <= 1'b0;
      left_hold <= '0;
      left_out  <= '0;
      right_out <= '0;
      valid     <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (restart) begin
        armed     <= 1'b0;
        started   <= 1'b0;
        have_left <= 1'b0;
      end else if (stb) begin
        if (!armed) begin
          armed <= 1'b1;
          ws_q  <= ws;
        end else if (ws != ws_q) begin
          ws_q <= ws;
          if (started) begin
            if (ws_q == left_level) begin
              left_hold <= samp;
              have_left <= 1'b1;
            end else begin
              if (have_left && pair_ok) begin
                left_out  <= left_hold;
                right_out <= samp;
                valid     <= 1'b1;
              end
              have_left <= 1'b0;
            end
          end
          started <= 1'b1;
          shreg   <= {{(SLOT_MAX-1){1'b0}}, din};
          pos     <= PW'(1);
        end else begin
          shreg <= {shreg[SLOT_MAX-2:0], din};
          if (pos != PW'(SLOT_MAX)) pos <= pos + PW'(1);
        end
      end
    end
  end

  // R9: the pair strobe lasts a single cycle
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R6: positions below the configured length are zero on presentation
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (rst)
    valid |-> (((left_out & ~keep_top) == '0) && ((right_out & ~keep_top) == '0)));

  // R2: a configuration write never gives a pair on the following cycles
  p_restart_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> !valid);

endmodule

// File: rtl/sa_receiver.sv
module sa_receiver
  import sa_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SLOT_MAX    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sclk,
  input  logic                lrck,
  input  logic                sdin,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_fmt,
  input  logic [1:0]          cfg_len,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                sample_valid,
  output logic [1:0]          ratio_code,
  output logic                ratio_error
);

  logic [2:0] raw_in, sync_out;
  logic       s_sclk, s_lr, s_sd;
  logic       sclk_q, lr_q, bit_stb, lr_rise;
  logic       is_i2s, ws_eff, err_next;
  cfg_t       cfg_q;

  assign raw_in = {sclk, lrck, sdin};

  sa_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (sync_out)
  );

  assign s_sclk = sync_out[2];
  assign s_lr   = sync_out[1];
  assign s_sd   = sync_out[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{fmt: FMT_I2S, len: LEN_24};
    end else if (cfg_wr) begin
      cfg_q <= '{fmt: cfg_fmt, len: cfg_len};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      sclk_q <= s_sclk;
      if (bit_stb) lr_q <= s_lr;
    end
  end

  assign bit_stb = s_sclk & ~sclk_q;
  assign lr_rise = bit_stb & s_lr & ~lr_q;
  assign is_i2s  = (cfg_q.fmt != FMT_LJ) && (cfg_q.fmt != FMT_RJ);
  assign ws_eff  = is_i2s ? lr_q : s_lr;

  sa_rx_ratio u_ratio (
    .clk        (clk),
    .rst        (rst),
    .step       (bit_stb),
    .rise       (lr_rise),
    .ratio_code (ratio_code),
    .err        (ratio_error),
    .err_next   (err_next)
  );

  sa_rx_capture #(.SAMPLE_W(SAMPLE_W), .SLOT_MAX(SLOT_MAX)) u_capture (
    .clk        (clk),
    .rst        (rst),
    .restart    (cfg_wr),
    .stb        (bit_stb),
    .din        (s_sd),
    .ws         (ws_eff),
    .left_level (~is_i2s),
    .right_just (cfg_q.fmt == FMT_RJ),
    .len_code   (cfg_q.len),
    .pair_ok    (~err_next),
    .left_out   (left_out),
    .right_out  (right_out),
    .valid      (sample_valid)
  );

  // R9: no pair is presented while the ratio flag is raised
  p_valid_clear_r9: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> !ratio_error);

endmodule

// File: tb/sa_receiver_tb.sv
module sa_receiver_tb;
  import sa_rx_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        sclk, lrck, sdin, cfg_wr;
  logic [1:0]  cfg_fmt, cfg_len;
  logic [23:0] left_out, right_out;
  logic        sample_valid, ratio_error;
  logic [1:0]  ratio_code;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  logic tx_hold = 1'b1;

  always #10 clk = ~clk;

  sa_receiver u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .lrck(lrck), .sdin(sdin),
    .cfg_wr(cfg_wr), .cfg_fmt(cfg_fmt), .cfg_len(cfg_len),
    .left_out(left_out), .right_out(right_out), .sample_valid(sample_valid),
    .ratio_code(ratio_code), .ratio_error(ratio_error)
  );

  always @(negedge clk) if (!rst && sample_valid) pulses++;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  len;
    logic [7:0]  bits;
    logic [23:0] l;
    logic [23:0] r;
    logic [23:0] el;
    logic [23:0] er;
    logic [1:0]  code;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{FMT_I2S, LEN_24, 8'd64, 24'hA5C3F1, 24'h5A3C0F, 24'hA5C3F1, 24'h5A3C0F, 2'd3},
    '{FMT_I2S, LEN_16, 8'd32, 24'h00BEEF, 24'h001234, 24'hBEEF00, 24'h123400, 2'd1},
    '{FMT_LJ,  LEN_24, 8'd48, 24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA, 2'd2},
    '{FMT_LJ,  LEN_20, 8'd64, 24'h0ABCDE, 24'h013579, 24'hABCDE0, 24'h135790, 2'd3},
    '{FMT_RJ,  LEN_24, 8'd64, 24'hC0FFEE, 24'h0BADF0, 24'hC0FFEE, 24'h0BADF0, 2'd3},
    '{FMT_RJ,  LEN_16, 8'd48, 24'h008001, 24'h007FFE, 24'h800100, 24'h7FFE00, 2'd2},
    '{FMT_RJ,  LEN_20, 8'd32, 24'h0FEDCB, 24'h012345, 24'h0EDCB0, 24'h023450, 2'd1},
    '{FMT_LJ,  LEN_24, 8'd32, 24'hABCDEF, 24'h654321, 24'hABCD00, 24'h654300, 2'd1},
    '{FMT_I2S, LEN_20, 8'd48, 24'h0FFFFF, 24'h000001, 24'hFFFFF0, 24'h000010, 2'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_slot(input logic lr, input logic d);
    sclk = 1'b0; lrck = lr; sdin = d;
    tick(4);
    sclk = 1'b1;
    tick(4);
  endtask

  function automatic logic chan_bit(input logic [1:0] fmt, input logic [1:0] lc,
                                    input int half, input int k, input logic [23:0] raw);
    int n;
    int idx;
    n = int'(len_bits(lc));
    if (fmt == FMT_RJ) begin
      idx = half - 1 - k;
      return (idx < n) ? raw[idx] : 1'b1;
    end
    idx = n - 1 - k;
    return (k < n) ? raw[idx] : 1'b1;
  endfunction

  task automatic send_frame(input logic [1:0] fmt, input logic [1:0] lc, input int bits,
                            input logic [23:0] l, input logic [23:0] r);
    int  half;
    logic i2s;
    half = bits / 2;
    i2s  = (fmt != FMT_LJ) && (fmt != FMT_RJ);
    for (int g = 0; g < bits; g++) begin
      logic first, cur, lr;
      int   k;
      first = (g < half);
      k     = first ? g : g - half;
      cur   = chan_bit(fmt, lc, half, k, first ? l : r);
      lr    = i2s ? !first : first;
      if (i2s) begin
        send_slot(lr, tx_hold);
        tx_hold = cur;
      end else begin
        send_slot(lr, cur);
      end
    end
  endtask

  task automatic write_cfg(input logic [1:0] fmt, input logic [1:0] lc);
    cfg_fmt = fmt; cfg_len = lc; cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
    tick(2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    tick(190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    sclk = 1'b0; lrck = 1'b0; sdin = 1'b0;
    cfg_wr = 1'b0; cfg_fmt = 2'd0; cfg_len = 2'd0;
    rst = 1'b1;
    tick(6);
    rst = 1'b0;
    tick(3);

    // R1 reset state
    check("R1 left_out", 32'(left_out), 32'h0);
    check("R1 right_out", 32'(right_out), 32'h0);
    check("R1 sample_valid", 32'(sample_valid), 32'h0);
    check("R1 ratio_error", 32'(ratio_error), 32'h1);
    check("R1 ratio_code", 32'(ratio_code), 32'h0);

    // R1/R2 default configuration is I2S 24-bit, R3 framing
    pulses = 0;
    repeat (5) send_frame(FMT_I2S, LEN_24, 64, 24'h112233, 24'h445566);
    tick(20);
    check("R1 default left", 32'(left_out), 32'h112233);
    check("R3 default right", 32'(right_out), 32'h445566);
    check("R9 default strobe seen", 32'(pulses > 0), 32'h1);

    // vector table: R3 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      write_cfg(VECS[v].fmt, VECS[v].len);
      pulses = 0;
      repeat (5) send_frame(VECS[v].fmt, VECS[v].len, int'(VECS[v].bits), VECS[v].l, VECS[v].r);
      tick(20);
      check($sformatf("R3/R4/R5/R6 vec%0d left", v), 32'(left_out), 32'(VECS[v].el));
      check($sformatf("R3/R4/R5/R6 vec%0d right", v), 32'(right_out), 32'(VECS[v].er));
      check($sformatf("R7 vec%0d ratio_code", v), 32'(ratio_code), 32'(VECS[v].code));
      check($sformatf("R8 vec%0d ratio_error", v), 32'(ratio_error), 32'h0);
      check($sformatf("R9 vec%0d strobe seen", v), 32'(pulses > 0), 32'h1);
    end

    // R8 unsupported 40-bit frames
    write_cfg(FMT_I2S, LEN_24);
    repeat (2) send_frame(FMT_I2S, LEN_24, 40, 24'h777777, 24'h888888);
    pulses = 0;
    repeat (2) send_frame(FMT_I2S, LEN_24, 40, 24'h777777, 24'h888888);
    tick(20);
    check("R8 error on 40-bit frames", 32'(ratio_error), 32'h1);
    check("R7 code for 40-bit frames", 32'(ratio_code), 32'h0);
    check("R9 no strobe while flagged", 32'(pulses), 32'h0);

    // R8 recovery needs two consecutive supported frames
    send_frame(FMT_I2S, LEN_24, 64, 24'h999999, 24'hAAAAAA);
    send_frame(FMT_I2S, LEN_24, 64, 24'h999999, 24'hAAAAAA);
    tick(20);
    check("R8 one supported frame keeps flag", 32'(ratio_error), 32'h1);
    send_frame(FMT_I2S, LEN_24, 64, 24'h999999, 24'hAAAAAA);
    tick(20);
    check("R8 second supported frame clears flag", 32'(ratio_error), 32'h0);
    check("R7 code after recovery", 32'(ratio_code), 32'h3);

    // R9 collision: justified mode, bad length judged on the edge closing the right channel
    write_cfg(FMT_LJ, LEN_24);
    repeat (4) send_frame(FMT_LJ, LEN_24, 64, 24'h0F0F0F, 24'hF0F0F0);
    pulses = 0;
    send_frame(FMT_LJ, LEN_24, 56, 24'h111111, 24'h222222);
    send_frame(FMT_LJ, LEN_24, 64, 24'h333333, 24'h444444);
    tick(20);
    check("R9 single strobe across bad frame", 32'(pulses), 32'h1);
    check("R8 flag set by 56-bit frame", 32'(ratio_error), 32'h1);
    check("R9 left kept from last good frame", 32'(left_out), 32'h0F0F0F);
    check("R9 right kept from last good frame", 32'(right_out), 32'hF0F0F0);
    check("R7 code after 56-bit frame", 32'(ratio_code), 32'h0);

    finish_run();
  end

endmodule